// File: doc/BRIEF.md
# SPI Status Flag Controller

This block owns the status byte of an SPI peripheral. A separate shift engine reports events to it: a transfer has finished, a received byte is ready to move into the data register, a transmit is in progress, the slave-select pin level, and whether the port runs as master. The CPU register bus reads and writes the status, data and control addresses. From these inputs the block keeps four error and completion flags, clears them only through ordered software access pairs, blocks data-register writes while a finished transfer has not been acknowledged, raises an interrupt request, and holds three software-owned bits. These bits gate the serial data output and drive slave-select management.

Every flag is a register that updates on the rising clock edge. The readback byte, the data-write permit, the interrupt request and the output enables are combinational views of that state and of the bus inputs in the current cycle. Each two-step clear has an "armed" bit. The first access of the pair sets it, only while its flag is 1. A new setting event for the same flag cancels it. When a flag is set and cleared in the same cycle, the set wins.

Top module: `spi_flag_ctrl`

## Requirements
- R1: Synchronous reset makes the status byte 8'h00 and removes every pending clear sequence. The readback layout is: bit 7 done, bit 6 collision, bit 5 overrun, bit 4 fault, bit 3 always 0, bit 2 output-off, bit 1 slave-select management, bit 0 slave-select level.
- R2: A bus write to the status address loads wdata[2:0] into bits 2..0. It leaves bits 7..3 unchanged, and bit 3 always reads 0.
- R3: The done flag (bit 7) sets on the cycle after `eng_xfer_done`. It clears only when a status read made while it is 1 is followed, in a later cycle, by a read or write of the data address.
- R4: A data-address write is passed on (`dr_wr_en`=1) unless the done flag is 1 and no status read has been made since it was set.
- R5: The collision flag (bit 6) sets after a data-address write made while `eng_tx_busy` is 1. It clears by the same status-read-then-data-access pair as the done flag.
- R6: The overrun flag (bit 5) sets after a cycle where `eng_rx_ready` is 1 while the done flag is 1. Any status read clears it.
- R7: The fault flag (bit 4) sets after `eng_ss_n` goes from 1 to 0 while `eng_master` is 1. It clears only when a status read or write made while it is 1 is followed by a control-address write.
- R8: `irq` equals `cfg_irq_en` AND (done OR overrun OR fault). The collision flag does not raise it.
- R9: `mosi_oe` = `cfg_spi_en` AND NOT output-off AND master. `miso_oe` = `cfg_spi_en` AND NOT output-off AND NOT master.
- R10: A setting event that arrives after the first access of a clear pair and before the second cancels the pair, so the flag stays 1 after the second access.
- R11: When a flag's setting event and its clearing access fall in the same cycle, the flag is 1 afterwards.
- R12: `ssm_en` and `ssi_lvl` show status bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Status byte readback |
| dr_wr_en | output | 1 | Data-register write permitted this cycle |
| eng_xfer_done | input | 1 | Engine: transfer finished |
| eng_rx_ready | input | 1 | Engine: received byte ready for the data register |
| eng_tx_busy | input | 1 | Engine: transmit in progress |
| eng_ss_n | input | 1 | Slave-select pin level |
| eng_master | input | 1 | Port is in master mode |
| cfg_spi_en | input | 1 | Peripheral enable from the control register |
| cfg_irq_en | input | 1 | Interrupt enable from the control register |
| irq | output | 1 | Interrupt request |
| mosi_oe | output | 1 | Master data output enable |
| miso_oe | output | 1 | Slave data output enable |
| ssm_en | output | 1 | Software slave-select management bit |
| ssi_lvl | output | 1 | Software slave-select level bit |

## Verification
The bench targets the ordering of the clear pairs. A data access with no status read before it must leave the done flag set. A design that cleared on either access alone would drop it. A transfer that finishes between the two accesses must survive the second one; a design without the cancel would lose a completed byte. Same-cycle set and clear must end with the flag set; getting the priority wrong would silently clear an overrun or completion. The bench also checks that the write block lifts only after a status read. A design that lifted it at the wrong time would either discard a valid data write or pass one through over unread data.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int NFLAG   = 4;
    localparam int IX_MODF = 0;
    localparam int IX_OVR  = 1;
    localparam int IX_WCOL = 2;
    localparam int IX_SPIF = 3;

    // flags cleared through an armed two-step sequence (overrun clears in one step)
    localparam logic [NFLAG-1:0] TWO_STEP_MASK = 4'b1101;

    typedef enum logic [1:0] {
        REG_CSR  = 2'd0,
        REG_DR   = 2'd1,
        REG_CR   = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic csr_rd;
        logic csr_wr;
        logic dr_rd;
        logic dr_wr;
        logic cr_wr;
    } bus_acc_t;

    typedef struct packed {
        logic sod;
        logic ssm;
        logic ssi;
    } ctl_bits_t;

    function automatic logic [7:0] pack_csr(input logic [NFLAG-1:0] fl, input ctl_bits_t c);
        return {fl, 1'b0, c};
    endfunction

endpackage

// File: rtl/spi_bus_decode.sv
module spi_bus_decode
    import spi_flag_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int A_CSR  = 0,
    parameter int A_DR   = 1,
    parameter int A_CR   = 2
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_acc_t          acc
);
    reg_sel_e sel;

    always_comb begin
        if (bus_addr == ADDR_W'(A_CSR))     sel = REG_CSR;
        else if (bus_addr == ADDR_W'(A_DR)) sel = REG_DR;
        else if (bus_addr == ADDR_W'(A_CR)) sel = REG_CR;
        else                                sel = REG_NONE;
    end

    always_comb begin
        acc        = '0;
        acc.csr_rd = bus_rd && (sel == REG_CSR);
        acc.csr_wr = bus_wr && (sel == REG_CSR);
        acc.dr_rd  = bus_rd && (sel == REG_DR);
        acc.dr_wr  = bus_wr && (sel == REG_DR);
        acc.cr_wr  = bus_wr && (sel == REG_CR);
    end
endmodule

// File: rtl/spi_flag_events.sv
module spi_flag_events
    import spi_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_acc_t         acc,
    input  logic             xfer_done,
    input  logic             rx_ready,
    input  logic             tx_busy,
    input  logic             ss_n,
    input  logic             master,
    input  logic             spif_now,
    output logic [NFLAG-1:0] set_evt,
    output logic [NFLAG-1:0] arm_req,
    output logic [NFLAG-1:0] clr_req
);
    logic ss_q;

    always_ff @(posedge clk) begin
        if (rst) ss_q <= 1'b1;
        else     ss_q <= ss_n;
    end

    always_comb begin
        set_evt          = '0;
        set_evt[IX_SPIF] = xfer_done;
        set_evt[IX_WCOL] = acc.dr_wr && tx_busy;
        set_evt[IX_OVR]  = rx_ready && spif_now;
        set_evt[IX_MODF] = master && !ss_n && ss_q;

        arm_req          = '0;
        arm_req[IX_SPIF] = acc.csr_rd;
        arm_req[IX_WCOL] = acc.csr_rd;
        arm_req[IX_MODF] = acc.csr_rd || acc.csr_wr;

        clr_req          = '0;
        clr_req[IX_SPIF] = acc.dr_rd || acc.dr_wr;
        clr_req[IX_WCOL] = acc.dr_rd || acc.dr_wr;
        clr_req[IX_OVR]  = acc.csr_rd;
        clr_req[IX_MODF] = acc.cr_wr;
    end
endmodule

// File: rtl/spi_seq_flag.sv
module spi_seq_flag #(
    parameter bit TWO_STEP = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic arm_req,
    input  logic clr_req,
    output logic flag,
    output logic armed
);
    generate
        if (TWO_STEP) begin : g_two_step
            logic flag_q, arm_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                    arm_q  <= 1'b0;
                end else if (set_evt) begin
                    flag_q <= 1'b1;
                    arm_q  <= 1'b0;
                end else if (arm_q && clr_req) begin
                    flag_q <= 1'b0;
                    arm_q  <= 1'b0;
                end else if (arm_req && flag_q) begin
                    arm_q  <= 1'b1;
                end
            end
            assign flag  = flag_q;
            assign armed = arm_q;
        end else begin : g_one_step
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst)          flag_q <= 1'b0;
                else if (set_evt) flag_q <= 1'b1;
                else if (clr_req) flag_q <= 1'b0;
            end
            assign flag  = flag_q;
            assign armed = 1'b0;
            logic unused_arm;
            assign unused_arm = arm_req;
        end
    endgenerate
endmodule

// File: rtl/spi_ctl_bits.sv
module spi_ctl_bits
    import spi_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_acc_t  acc,
    input  logic [2:0] wdata,
    input  logic      spi_en,
    input  logic      master,
    output ctl_bits_t ctl,
    output logic      mosi_oe,
    output logic      miso_oe
);
    ctl_bits_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)             ctl_q <= '0;
        else if (acc.csr_wr) ctl_q <= ctl_bits_t'(wdata);
    end

    logic drive_ok;
    assign drive_ok = spi_en && !ctl_q.sod;
    assign mosi_oe  = drive_ok && master;
    assign miso_oe  = drive_ok && !master;
    assign ctl      = ctl_q;
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int A_CSR  = 0,
    parameter int A_DR   = 1,
    parameter int A_CR   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        csr_rdata,
    output logic              dr_wr_en,
    input  logic              eng_xfer_done,
    input  logic              eng_rx_ready,
    input  logic              eng_tx_busy,
    input  logic              eng_ss_n,
    input  logic              eng_master,
    input  logic              cfg_spi_en,
    input  logic              cfg_irq_en,
    output logic              irq,
    output logic              mosi_oe,
    output logic              miso_oe,
    output logic              ssm_en,
    output logic              ssi_lvl
);
    bus_acc_t         acc;
    ctl_bits_t        ctl;
    logic [NFLAG-1:0] flags, armed, set_evt, arm_req, clr_req;
    logic             spif_armed;

    spi_bus_decode #(
        .ADDR_W(ADDR_W), .A_CSR(A_CSR), .A_DR(A_DR), .A_CR(A_CR)
    ) u_dec (
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .acc(acc)
    );

    spi_flag_events u_evt (
        .clk(clk), .rst(rst), .acc(acc),
        .xfer_done(eng_xfer_done), .rx_ready(eng_rx_ready), .tx_busy(eng_tx_busy),
        .ss_n(eng_ss_n), .master(eng_master), .spif_now(flags[IX_SPIF]),
        .set_evt(set_evt), .arm_req(arm_req), .clr_req(clr_req)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        spi_seq_flag #(.TWO_STEP(TWO_STEP_MASK[i])) u_flag (
            .clk(clk), .rst(rst),
            .set_evt(set_evt[i]), .arm_req(arm_req[i]), .clr_req(clr_req[i]),
            .flag(flags[i]), .armed(armed[i])
        );
    end

    spi_ctl_bits u_ctl (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata[2:0]),
        .spi_en(cfg_spi_en), .master(eng_master),
        .ctl(ctl), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
    );

    assign spif_armed = armed[IX_SPIF];
    assign dr_wr_en   = acc.dr_wr && !(flags[IX_SPIF] && !spif_armed);
    assign irq        = cfg_irq_en && (flags[IX_SPIF] || flags[IX_OVR] || flags[IX_MODF]);
    assign csr_rdata  = pack_csr(flags, ctl);
    assign ssm_en     = ctl.ssm;
    assign ssi_lvl    = ctl.ssi;

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[7:3], armed[IX_WCOL], armed[IX_MODF], armed[IX_OVR]};
endmodule

// File: rtl/spi_flag_ctrl_sva.sv
module spi_flag_ctrl_sva #(
    parameter int ADDR_W = 3,
    parameter int A_CSR  = 0,
    parameter int A_DR   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        csr_rdata,
    input logic              dr_wr_en,
    input logic              eng_xfer_done,
    input logic              eng_rx_ready,
    input logic              eng_tx_busy,
    input logic              eng_ss_n,
    input logic              eng_master,
    input logic              cfg_irq_en,
    input logic              irq,
    input logic              mosi_oe,
    input logic              miso_oe,
    input logic              spif_armed
);
    logic csr_wr_c, dr_wr_c, ss_q;
    assign csr_wr_c = bus_wr && (bus_addr == ADDR_W'(A_CSR));
    assign dr_wr_c  = bus_wr && (bus_addr == ADDR_W'(A_DR));

    always_ff @(posedge clk) begin
        if (rst) ss_q <= 1'b1;
        else     ss_q <= eng_ss_n;
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> csr_rdata == 8'h00);

    p_ctl_load_r2: assert property (@(posedge clk) disable iff (rst)
        csr_wr_c |=> csr_rdata[2:0] == $past(bus_wdata[2:0]));

    p_done_set_r3: assert property (@(posedge clk) disable iff (rst)
        eng_xfer_done |=> csr_rdata[7]);

    p_write_block_r4: assert property (@(posedge clk) disable iff (rst)
        (dr_wr_c && csr_rdata[7] && !spif_armed) |-> !dr_wr_en);

    p_coll_set_r5: assert property (@(posedge clk) disable iff (rst)
        (dr_wr_c && eng_tx_busy) |=> csr_rdata[6]);

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_ready && csr_rdata[7]) |=> csr_rdata[5]);

    p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_master && !eng_ss_n && ss_q) |=> csr_rdata[4]);

    p_irq_done_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_irq_en && csr_rdata[7]) |-> irq);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_irq_en |-> !irq);

    p_out_off_r9: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[2] |-> (!mosi_oe && !miso_oe));

    p_one_driver_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mosi_oe, miso_oe}));

    logic unused_sva;
    assign unused_sva = bus_rd;
endmodule

bind spi_flag_ctrl spi_flag_ctrl_sva #(
    .ADDR_W(ADDR_W), .A_CSR(A_CSR), .A_DR(A_DR)
) u_sva (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .csr_rdata(csr_rdata), .dr_wr_en(dr_wr_en),
    .eng_xfer_done(eng_xfer_done), .eng_rx_ready(eng_rx_ready),
    .eng_tx_busy(eng_tx_busy), .eng_ss_n(eng_ss_n), .eng_master(eng_master),
    .cfg_irq_en(cfg_irq_en), .irq(irq), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
    .spif_armed(spif_armed)
);

// File: tb/spi_flag_ctrl_tb.sv
module spi_flag_ctrl_tb;
    localparam int AW = 3;
    localparam logic [AW-1:0] AD_CSR = 3'd0, AD_DR = 3'd1, AD_CR = 3'd2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, bus_rd = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, csr_rdata;
    logic dr_wr_en, irq, mosi_oe, miso_oe, ssm_en, ssi_lvl;
    logic xfer = 0, rxr = 0, busy = 0, ss_n = 1, master = 0, spi_en = 0, irq_en = 0;

    spi_flag_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .csr_rdata(csr_rdata), .dr_wr_en(dr_wr_en),
        .eng_xfer_done(xfer), .eng_rx_ready(rxr), .eng_tx_busy(busy),
        .eng_ss_n(ss_n), .eng_master(master), .cfg_spi_en(spi_en), .cfg_irq_en(irq_en),
        .irq(irq), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ssm_en(ssm_en), .ssi_lvl(ssi_lvl)
    );

    int vecs = 0, fails = 0;
    bit live = 0, done = 0;

    // reference model state
    bit m_done, m_coll, m_ovr, m_flt, a_done, a_coll, a_flt, m_sod, m_ssm, m_ssi, m_ssq;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_byte();
        return {m_done, m_coll, m_ovr, m_flt, 1'b0, m_sod, m_ssm, m_ssi};
    endfunction

    task automatic compare();
        logic [7:0] e = m_byte();
        bit dw = bus_wr && bus_addr == AD_DR;
        bit e_wen = dw && !(m_done && !a_done);
        bit e_irq = irq_en && (m_done || m_ovr || m_flt);
        bit on = spi_en && !m_sod;
        chk(csr_rdata[7] == e[7], "R3 done flag", csr_rdata[7], e[7]);
        chk(csr_rdata[6] == e[6], "R5 collision flag", csr_rdata[6], e[6]);
        chk(csr_rdata[5] == e[5], "R6 overrun flag", csr_rdata[5], e[5]);
        chk(csr_rdata[4] == e[4], "R7 fault flag", csr_rdata[4], e[4]);
        chk(csr_rdata[3:0] == e[3:0], "R2 low bits", csr_rdata[3:0], e[3:0]);
        chk(dr_wr_en == e_wen, "R4 write permit", dr_wr_en, e_wen);
        chk(irq == e_irq, "R8 irq", irq, e_irq);
        chk({mosi_oe, miso_oe} == {on && master, on && !master}, "R9 enables",
            {mosi_oe, miso_oe}, {on && master, on && !master});
        chk({ssm_en, ssi_lvl} == {m_ssm, m_ssi}, "R12 ss bits", {ssm_en, ssi_lvl}, {m_ssm, m_ssi});
    endtask

    task automatic model_update();
        bit cr = bus_rd && bus_addr == AD_CSR, cw = bus_wr && bus_addr == AD_CSR;
        bit dr = bus_rd && bus_addr == AD_DR,  dw = bus_wr && bus_addr == AD_DR;
        bit kw = bus_wr && bus_addr == AD_CR;
        bit s_done = xfer, s_coll = dw && busy, s_ovr = rxr && m_done;
        bit s_flt = master && !ss_n && m_ssq;
        if (rst) begin
            {m_done, m_coll, m_ovr, m_flt, a_done, a_coll, a_flt, m_sod, m_ssm, m_ssi} = '0;
            m_ssq = 1;
            return;
        end
        m_ssq = ss_n;
        if (s_done) begin m_done = 1; a_done = 0; end
        else if (a_done && (dr || dw)) begin m_done = 0; a_done = 0; end
        else if (cr && m_done) a_done = 1;
        if (s_coll) begin m_coll = 1; a_coll = 0; end
        else if (a_coll && (dr || dw)) begin m_coll = 0; a_coll = 0; end
        else if (cr && m_coll) a_coll = 1;
        if (s_ovr) m_ovr = 1;
        else if (cr) m_ovr = 0;
        if (s_flt) begin m_flt = 1; a_flt = 0; end
        else if (a_flt && kw) begin m_flt = 0; a_flt = 0; end
        else if ((cr || cw) && m_flt) a_flt = 1;
        if (cw) {m_sod, m_ssm, m_ssi} = bus_wdata[2:0];
    endtask

    task automatic step();
        #1;
        if (live) compare();
        model_update();
        @(posedge clk);
        live = 1;
        @(negedge clk);
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; xfer = 0; rxr = 0; bus_addr = '0;
    endtask

    task automatic acc(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
        bus_rd = !wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic op(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
        acc(wr, a, d); step(); idle();
    endtask

    task automatic expect_byte(input logic [7:0] e, input string req);
        #1 chk(csr_rdata == e, req, csr_rdata, e);
    endtask

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        expect_byte(8'h00, "R1 reset value");

        spi_en = 1; master = 1;
        op(1, AD_CSR, 8'hFF);
        expect_byte(8'h07, "R2 only low bits load");
        chk({ssm_en, ssi_lvl} == 2'b11, "R12 ss bits", {ssm_en, ssi_lvl}, 3);
        chk(!mosi_oe && !miso_oe, "R9 output off", {mosi_oe, miso_oe}, 0);
        op(1, AD_CSR, 8'h00);
        chk(mosi_oe && !miso_oe, "R9 master drive", {mosi_oe, miso_oe}, 2);

        irq_en = 1;
        xfer = 1; step(); idle();
        expect_byte(8'h80, "R3 done sets");
        chk(irq, "R8 irq from done", irq, 1);
        acc(1, AD_DR, 8'h5A);
        #1 chk(!dr_wr_en, "R4 write blocked", dr_wr_en, 0);
        step(); idle();
        expect_byte(8'h80, "R3 no clear without status read");
        op(0, AD_CSR, 0);
        acc(1, AD_DR, 8'h5A);
        #1 chk(dr_wr_en, "R4 write after status read", dr_wr_en, 1);
        step(); idle();
        expect_byte(8'h00, "R3 pair clears");

        xfer = 1; step(); idle();
        rxr = 1; step(); idle();
        expect_byte(8'hA0, "R6 overrun sets");
        op(0, AD_CSR, 0);
        expect_byte(8'h80, "R6 status read clears");
        op(0, AD_DR, 0);

        busy = 1; op(1, AD_DR, 8'h11); busy = 0;
        expect_byte(8'h40, "R5 collision sets");
        chk(!irq, "R8 collision no irq", irq, 0);
        op(0, AD_DR, 0);
        expect_byte(8'h40, "R5 no clear without status read");
        op(0, AD_CSR, 0); op(0, AD_DR, 0);
        expect_byte(8'h00, "R5 pair clears");

        ss_n = 1; step(); ss_n = 0; step();
        expect_byte(8'h10, "R7 fault sets");
        op(1, AD_CR, 0);
        expect_byte(8'h10, "R7 control write alone");
        op(0, AD_CSR, 0); op(1, AD_CR, 0);
        expect_byte(8'h00, "R7 pair clears");
        ss_n = 1; step();

        xfer = 1; step(); idle();
        op(0, AD_CSR, 0);
        xfer = 1; step(); idle();
        op(0, AD_DR, 0);
        expect_byte(8'h80, "R10 rearm needed");
        op(0, AD_CSR, 0); op(0, AD_DR, 0);

        xfer = 1; step(); idle();
        op(0, AD_CSR, 0);
        acc(1, AD_DR, 8'h22); xfer = 1; step(); idle();
        expect_byte(8'h80, "R11 set beats clear");
        xfer = 1; step(); idle();
        rxr = 1; step(); idle();
        acc(0, AD_CSR, 0); rxr = 1; step(); idle();
        expect_byte(8'hA0, "R11 overrun set beats read");
        op(0, AD_CSR, 0); op(0, AD_DR, 0);
        expect_byte(8'h00, "R11 cleanup");

        for (int i = 0; i < 4000; i++) begin
            int k = $urandom_range(0, 7);
            idle();
            xfer = ($urandom_range(0, 5) == 0);
            rxr = ($urandom_range(0, 7) == 0);
            busy = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0) ss_n = !ss_n;
            if ($urandom_range(0, 63) == 0) master = !master;
            if ($urandom_range(0, 31) == 0) spi_en = !spi_en;
            if ($urandom_range(0, 31) == 0) irq_en = !irq_en;
            if (k < 6) acc(k[0], AW'(k >> 1), 8'($urandom));
            else if (k == 6) acc($urandom_range(0, 1) == 1, 3'd3, 8'($urandom));
            step();
        end
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule